// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block is one node of a two-dimensional mesh network. It has five ports: one toward the attached core (local) and one toward each compass neighbour. Every input has a short flit queue. Flits travel in packets: a head flit opens a packet and body flits follow it. A tail flit closes the packet. A packet of one flit is a single flit, which both opens and closes it. The head carries the output port it must take in this node. The previous node computed that port, so no route lookup sits in front of allocation here.

When a head flit reaches the front of its queue, it bids for its output. Each output has its own round-robin arbiter. A granted output stays reserved for that input until the closing flit has been forwarded. Each forwarded flit is loaded into the output register one cycle after the grant and leaves on the link from there. On the way out, an opening flit has its hop offsets advanced by the hop just taken. The port for the following node is then written into it, with X resolved before Y. Every link uses a valid/ready handshake.

Top module: `wh_mesh_router`

## Requirements
- R1: After a synchronous active-low reset, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: An input takes a flit at a rising edge only when its valid and ready are both 1. Ready is 0 exactly while the queue holds DEPTH flits (default 4). A flit offered while ready is 0 is dropped and never appears on any output.
- R3: An opening flit leaves on the port named by its route field, flit bits [29:27]. Port codes: 0 local, 1 north, 2 south, 3 east, 4 west.
- R4: On an opening flit the router rewrites its fields before output. The signed offsets dx (bits [26:23]) and dy (bits [22:19]) step one hop toward zero: east lowers dx, west raises dx, north lowers dy, south raises dy, local leaves both. The route field becomes the port the next node must take, chosen by the sign of dx first and by dy only when dx is 0. Offsets of 0,0 select local. The payload in bits [18:0] is unchanged.
- R5: An opening flit accepted at rising edge E into an idle router is on its output, with out_valid high, after edge E+2 and not before.
- R6: The kind field, bits [31:30], is 00 body, 01 head, 10 tail, 11 single. Body and tail flits follow the reserved output unchanged. Packets sharing an output never interleave. A reservation ends on the cycle its tail or single flit is forwarded.
- R7: Round-robin priority moves to the input after the last granted input only when that input's packet is released. Among simultaneous requests, the first input at or after that position in port-code order wins. Priority starts at input 0 after reset.
- R8: A blocked opening flit stalls every flit behind it in the same queue, even when those flits target an idle output.
- R9: While an output shows out_valid high and its out_ready is low, the output keeps out_valid high and holds out_flit stable.
- R10: At no time does one input hold a reservation on two outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 5 | Per-input flit offered (bit index = port code) |
| in_ready | output | 5 | Per-input queue has room |
| in_flit | input | 5*FLIT_W | Per-input flit, port p in slice [p*FLIT_W +: FLIT_W] |
| out_valid | output | 5 | Per-output flit present |
| out_ready | input | 5 | Per-output downstream can take the flit |
| out_flit | output | 5*FLIT_W | Per-output flit, same slicing as in_flit |

## Verification
Suppose a reservation is left stuck or released early. The affected output then goes silent, or another input's flits are spliced into a packet. This shows up in the flit order on that port within a few cycles of the packet's tail. A wrong round-robin pointer shows up only on the next contended packet boundary, as the wrong head leading the burst. Lookahead faults appear as wrong offsets or route fields on the very first output cycle of a head, two edges after its acceptance. Queue count errors appear as a ready that drops early, or as a dropped flit missing from a later output sequence.

// File: rtl/wh_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the wormhole router: port codes, flit kinds and
// the helpers that classify a flit as opening or closing a packet.
package wh_pkg;
    localparam int unsigned NPORT  = 5;
    localparam int unsigned PORT_W = 3;
    localparam int unsigned KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        K_BODY   = 2'b00,
        K_HEAD   = 2'b01,
        K_TAIL   = 2'b10,
        K_SINGLE = 2'b11
    } flit_kind_e;

    typedef enum logic [PORT_W-1:0] {
        P_LOCAL = 3'd0,
        P_NORTH = 3'd1,
        P_SOUTH = 3'd2,
        P_EAST  = 3'd3,
        P_WEST  = 3'd4
    } port_e;

    // True for a flit that starts a packet and so needs allocation.
    function automatic logic opens_packet(input logic [KIND_W-1:0] k);
        return (k == K_HEAD) || (k == K_SINGLE);
    endfunction

    // True for a flit that ends a packet and so frees the output.
    function automatic logic closes_packet(input logic [KIND_W-1:0] k);
        return (k == K_TAIL) || (k == K_SINGLE);
    endfunction
endpackage

// File: rtl/wh_flit_queue.sv
`timescale 1ns/1ps
// Circular flit queue for one router input.
// Assumes DEPTH >= 2. Pushes while full and pops while empty are ignored.
module wh_flit_queue #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;
    logic [CW-1:0] count;
    logic          do_push;
    logic          do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign rdata   = slots[rd_ptr];

    // Store an accepted flit in the write slot.
    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wr_ptr] <= wdata;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
                count <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/wh_rr_arbiter.sv
`timescale 1ns/1ps
// Per-output allocator: a registered reservation with round-robin choice.
// While free, it grants the first requester at or after the priority
// pointer. The grant holds until 'done'. Then the pointer moves past the
// released owner and the output is free again on the next cycle.
module wh_rr_arbiter #(
    parameter int unsigned N  = 5,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          done,
    output logic          busy,
    output logic [IW-1:0] owner
);
    logic [IW-1:0] ptr;
    logic [IW-1:0] pick;
    logic          found;

    // Add k to an index modulo N.
    function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] a, input int unsigned k);
        int unsigned s;
        s = 32'(a) + k;
        if (s >= N) begin
            s = s - N;
        end
        return IW'(s);
    endfunction

    // Scan from the pointer; the nearest requester wins.
    always_comb begin
        found = 1'b0;
        pick  = ptr;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[wrap_add(ptr, unsigned'(k))]) begin
                found = 1'b1;
                pick  = wrap_add(ptr, unsigned'(k));
            end
        end
    end

    // Hold the reservation; rotate priority only at packet release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            owner <= '0;
            ptr   <= '0;
        end else if (busy) begin
            if (done) begin
                busy <= 1'b0;
                ptr  <= wrap_add(owner, 1);
            end
        end else if (found) begin
            busy  <= 1'b1;
            owner <= pick;
        end
    end
endmodule

// File: rtl/wh_lookahead.sv
`timescale 1ns/1ps
// Lookahead route stage for one output port (combinational).
// For an opening flit it advances the hop offsets by this port's hop.
// It then writes the XY route of the next node into the route field.
// Other flits pass through untouched. Field layout from the MSB down:
// kind, route, dx, dy, payload.
module wh_lookahead
    import wh_pkg::*;
#(
    parameter int unsigned W     = 32,
    parameter int unsigned OFS_W = 4,
    parameter int unsigned PORT  = 0
) (
    input  logic [W-1:0] flit_i,
    output logic [W-1:0] flit_o
);
    localparam int KIND_HI  = W - 1;
    localparam int ROUTE_HI = W - 1 - KIND_W;
    localparam int DX_HI    = ROUTE_HI - PORT_W;
    localparam int DY_HI    = DX_HI - OFS_W;
    localparam int STEP_X   = (PORT == int'(P_EAST)) ? -1 : (PORT == int'(P_WEST)) ? 1 : 0;
    localparam int STEP_Y   = (PORT == int'(P_NORTH)) ? -1 : (PORT == int'(P_SOUTH)) ? 1 : 0;

    logic signed [OFS_W-1:0] ndx;
    logic signed [OFS_W-1:0] ndy;
    logic [PORT_W-1:0]       nroute;

    // Offsets remaining once this hop is taken.
    always_comb begin
        ndx = flit_i[DX_HI -: OFS_W] + OFS_W'(STEP_X);
        ndy = flit_i[DY_HI -: OFS_W] + OFS_W'(STEP_Y);
    end

    // Dimension-ordered choice for the next node: X first, then Y.
    always_comb begin
        if (!ndx[OFS_W-1] && (ndx != '0)) begin
            nroute = P_EAST;
        end else if (ndx[OFS_W-1]) begin
            nroute = P_WEST;
        end else if (!ndy[OFS_W-1] && (ndy != '0)) begin
            nroute = P_NORTH;
        end else if (ndy[OFS_W-1]) begin
            nroute = P_SOUTH;
        end else begin
            nroute = P_LOCAL;
        end
    end

    // Rewrite only opening flits.
    always_comb begin
        flit_o = flit_i;
        if (opens_packet(flit_i[KIND_HI -: KIND_W])) begin
            flit_o[ROUTE_HI -: PORT_W] = nroute;
            flit_o[DX_HI -: OFS_W]     = ndx;
            flit_o[DY_HI -: OFS_W]     = ndy;
        end
    end
endmodule

// File: rtl/wh_mesh_router.sv
`timescale 1ns/1ps
// Five-port wormhole router for a 2D mesh.
// An opening flit at a queue front requests the port in its route field.
// The per-output arbiter registers a grant (allocation). The reserved
// input then feeds the output register through the crossbar and lookahead
// stage (traversal), and the register drives the link. The reservation
// ends when a tail or single flit is forwarded.
// Assumes opening flits carry a valid port code (0..4).
module wh_mesh_router
    import wh_pkg::*;
#(
    parameter int unsigned FLIT_W = 32,
    parameter int unsigned OFS_W  = 4,
    parameter int unsigned DEPTH  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT-1:0]          in_valid,
    output logic [NPORT-1:0]          in_ready,
    input  logic [NPORT*FLIT_W-1:0]   in_flit,
    output logic [NPORT-1:0]          out_valid,
    input  logic [NPORT-1:0]          out_ready,
    output logic [NPORT*FLIT_W-1:0]   out_flit
);
    localparam int unsigned IW       = $clog2(NPORT);
    localparam int          KIND_HI  = FLIT_W - 1;
    localparam int          ROUTE_HI = FLIT_W - 1 - KIND_W;

    logic [FLIT_W-1:0] q_head [NPORT];
    logic [NPORT-1:0]  q_full;
    logic [NPORT-1:0]  q_empty;
    logic [NPORT-1:0]  q_pop;
    logic [NPORT-1:0]  req_to [NPORT];
    logic [NPORT-1:0]  out_busy;
    logic [IW-1:0]     out_owner [NPORT];
    logic [NPORT-1:0]  xfer;
    logic [NPORT-1:0]  done;
    logic [NPORT-1:0]  sel_has;
    logic [FLIT_W-1:0] sel_flit [NPORT];
    logic [FLIT_W-1:0] la_flit [NPORT];
    logic [FLIT_W-1:0] odata [NPORT];
    logic [NPORT-1:0]  ov;

    // Input side: one queue per port.
    for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
        wh_flit_queue #(.W(FLIT_W), .DEPTH(DEPTH)) u_queue (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (in_valid[gi]),
            .wdata (in_flit[gi*FLIT_W +: FLIT_W]),
            .pop   (q_pop[gi]),
            .rdata (q_head[gi]),
            .full  (q_full[gi]),
            .empty (q_empty[gi])
        );
        assign in_ready[gi] = !q_full[gi];
    end

    // Requests: a queue front that opens a packet bids for its route port.
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                req_to[o][i] = !q_empty[i]
                            && opens_packet(q_head[i][KIND_HI -: KIND_W])
                            && (q_head[i][ROUTE_HI -: PORT_W] == PORT_W'(o));
            end
        end
    end

    // Pop each input whose flit an output takes this cycle.
    always_comb begin
        q_pop = '0;
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                if (xfer[o] && (out_owner[o] == IW'(i))) begin
                    q_pop[i] = 1'b1;
                end
            end
        end
    end

    // Output side: allocator, crossbar leg, lookahead and link register.
    for (genvar go = 0; go < NPORT; go++) begin : g_out
        wh_rr_arbiter #(.N(NPORT), .IW(IW)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_to[go]),
            .done  (done[go]),
            .busy  (out_busy[go]),
            .owner (out_owner[go])
        );

        // Crossbar leg: pick the reserved input's queue front.
        always_comb begin
            sel_flit[go] = '0;
            sel_has[go]  = 1'b0;
            for (int i = 0; i < NPORT; i++) begin
                if (out_owner[go] == IW'(i)) begin
                    sel_flit[go] = q_head[i];
                    sel_has[go]  = !q_empty[i];
                end
            end
        end

        assign xfer[go] = out_busy[go] && sel_has[go] && (!ov[go] || out_ready[go]);
        assign done[go] = xfer[go] && closes_packet(sel_flit[go][KIND_HI -: KIND_W]);

        wh_lookahead #(.W(FLIT_W), .OFS_W(OFS_W), .PORT(go)) u_la (
            .flit_i (sel_flit[go]),
            .flit_o (la_flit[go])
        );

        // Link register: load on traversal, empty once taken downstream.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ov[go]    <= 1'b0;
                odata[go] <= '0;
            end else if (xfer[go]) begin
                ov[go]    <= 1'b1;
                odata[go] <= la_flit[go];
            end else if (out_ready[go]) begin
                ov[go] <= 1'b0;
            end
        end

        assign out_valid[go]                   = ov[go];
        assign out_flit[go*FLIT_W +: FLIT_W]   = odata[go];
    end
endmodule

// File: rtl/wh_mesh_router_chk.sv
`timescale 1ns/1ps
// Property checker for wh_mesh_router, attached by bind below.
// It sees the ports and the per-output reservation state.
module wh_mesh_router_chk
    import wh_pkg::*;
#(
    parameter int unsigned FLIT_W = 32,
    parameter int unsigned OFS_W  = 4,
    parameter int unsigned IW     = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NPORT-1:0]        out_valid,
    input logic [NPORT-1:0]        out_ready,
    input logic [NPORT*FLIT_W-1:0] out_flit,
    input logic [NPORT-1:0]        out_busy,
    input logic [IW-1:0]           out_owner [NPORT]
);
    localparam int KIND_HI = FLIT_W - 1;
    localparam int DX_HI   = FLIT_W - 1 - KIND_W - PORT_W;
    localparam int DY_HI   = DX_HI - OFS_W;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // A stalled link flit is held unchanged.
        p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[p] && !out_ready[p]
            |=> out_valid[p] && $stable(out_flit[p*FLIT_W +: FLIT_W]));

        if (p == int'(P_LOCAL)) begin : g_local
            // Delivered packets have no hops left.
            p_local_arrived_r4: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[p] && opens_packet(out_flit[p*FLIT_W + KIND_HI -: KIND_W])
                |-> (out_flit[p*FLIT_W + DX_HI -: OFS_W] == '0)
                 && (out_flit[p*FLIT_W + DY_HI -: OFS_W] == '0));
        end

        if ((p == int'(P_NORTH)) || (p == int'(P_SOUTH))) begin : g_vert
            // X is finished before any Y hop.
            p_xfirst_r4: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[p] && opens_packet(out_flit[p*FLIT_W + KIND_HI -: KIND_W])
                |-> (out_flit[p*FLIT_W + DX_HI -: OFS_W] == '0));
        end

        for (genvar q = p + 1; q < NPORT; q++) begin : g_pair
            // One input never reserves two outputs.
            p_owner_unique_r10: assert property (@(posedge clk) disable iff (!rst_n)
                out_busy[p] && out_busy[q] |-> (out_owner[p] != out_owner[q]));
        end
    end
endmodule

bind wh_mesh_router wh_mesh_router_chk #(
    .FLIT_W (FLIT_W),
    .OFS_W  (OFS_W),
    .IW     (IW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_flit  (out_flit),
    .out_busy  (out_busy),
    .out_owner (out_owner)
);

// File: tb/wh_mesh_router_test.sv
`timescale 1ns/1ps
// Self-checking bench for wh_mesh_router: a routing vector table, then
// directed tests for reset, contention, backpressure and dropped offers.
module wh_mesh_router_test;
    localparam int NP = 5;
    localparam int FW = 32;
    localparam int DEPTH = 4;
    localparam int NV = 8;
    // Columns: src, route, dx, dy, exp_port, exp_dx, exp_dy, exp_next_route
    localparam int VEC [NV][8] = '{
        '{4, 3,  2,  1, 3,  1,  1, 3},
        '{0, 3,  1, -2, 3,  0, -2, 2},
        '{3, 4, -1,  0, 4,  0,  0, 0},
        '{2, 1,  0,  3, 1,  0,  2, 1},
        '{1, 2,  0, -1, 2,  0,  0, 0},
        '{3, 0,  0,  0, 0,  0,  0, 0},
        '{0, 4, -3,  2, 4, -2,  2, 4},
        '{1, 2,  0, -7, 2,  0, -6, 2}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NP-1:0]      in_valid = '0;
    logic [NP-1:0]      in_ready;
    logic [NP*FW-1:0]   in_flit = '0;
    logic [NP-1:0]      out_valid;
    logic [NP-1:0]      out_ready = '1;
    logic [NP*FW-1:0]   out_flit;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;

    logic [FW-1:0] log_f [NP][16];
    int            log_n [NP];

    wh_mesh_router uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_flit   (in_flit),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_flit  (out_flit)
    );

    always #4 clk = ~clk;

    // Record every link handshake, sampled mid-phase.
    always @(negedge clk) begin
        #2;
        for (int p = 0; p < NP; p++) begin
            if (out_valid[p] && out_ready[p]) begin
                if (log_n[p] < 16) log_f[p][log_n[p]] = out_flit[p*FW +: FW];
                log_n[p] = log_n[p] + 1;
            end
        end
    end

    function automatic logic [FW-1:0] mk(input int kind, input int route, input int dx,
                                         input int dy, input int pay);
        return {2'(kind), 3'(route), 4'(dx), 4'(dy), 19'(pay)};
    endfunction

    task automatic check(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_logs();
        for (int p = 0; p < NP; p++) log_n[p] = 0;
    endtask

    // Called at a negedge; returns at the negedge after acceptance.
    task automatic push(input int p, input logic [FW-1:0] f);
        in_valid[p] = 1'b1;
        in_flit[p*FW +: FW] = f;
        while (!in_ready[p]) @(negedge clk);
        @(negedge clk);
        in_valid[p] = 1'b0;
    endtask

    // Two three-flit packets offered on two inputs in the same cycles.
    task automatic two_packets(input int a, input int b, input int pa, input int pb);
        for (int k = 0; k < 3; k++) begin
            in_valid[a] = 1'b1;
            in_valid[b] = 1'b1;
            in_flit[a*FW +: FW] = (k == 0) ? mk(1, 3, 2, 0, pa) : mk(2*(k-1), 0, 0, 0, pa + k);
            in_flit[b*FW +: FW] = (k == 0) ? mk(1, 3, 2, 0, pb) : mk(2*(k-1), 0, 0, 0, pb + k);
            @(negedge clk);
        end
        in_valid = '0;
    endtask

    initial begin
        for (int p = 0; p < NP; p++) log_n[p] = 0;
        do_reset();

        // R1: reset state
        check("R1 out_valid after reset", FW'(out_valid), '0);
        check("R1 in_ready after reset", FW'(in_ready), FW'(5'b11111));

        // R3 R4 R5: routing and lookahead vectors
        for (int v = 0; v < NV; v++) begin
            push(VEC[v][0], mk(3, VEC[v][1], VEC[v][2], VEC[v][3], 256 + v));
            @(negedge clk);
            check("R5 no output one edge after accept", FW'(out_valid), '0);
            @(negedge clk);
            check("R3 output port select", FW'(out_valid), FW'(1 << VEC[v][4]));
            check("R4 lookahead rewrite", out_flit[VEC[v][4]*FW +: FW],
                  mk(3, VEC[v][7], VEC[v][5], VEC[v][6], 256 + v));
            repeat (2) @(negedge clk);
        end

        // R6 R7: contention on east, pointer starts at 0 after reset
        do_reset();
        clear_logs();
        two_packets(0, 2, 16, 32);
        repeat (14) @(negedge clk);
        check("R6 east flit count round 1", FW'(log_n[3]), FW'(6));
        check("R7 local head first", log_f[3][0], mk(1, 3, 1, 0, 16));
        check("R6 local body unchanged", log_f[3][1], mk(0, 0, 0, 0, 17));
        check("R6 local tail unchanged", log_f[3][2], mk(2, 0, 0, 0, 18));
        check("R6 south head after tail", log_f[3][3], mk(1, 3, 1, 0, 32));
        check("R6 south tail last", log_f[3][5], mk(2, 0, 0, 0, 34));
        // R7: pointer now past south, so west beats local
        clear_logs();
        two_packets(0, 4, 48, 64);
        repeat (14) @(negedge clk);
        check("R6 east flit count round 2", FW'(log_n[3]), FW'(6));
        check("R7 west head first after rotation", log_f[3][0], mk(1, 3, 1, 0, 64));
        check("R7 local head second", log_f[3][3], mk(1, 3, 1, 0, 48));

        // R2 R8 R9: blocked east output, queue fills, north waits
        do_reset();
        clear_logs();
        out_ready[3] = 1'b0;
        for (int k = 0; k < 4; k++) push(0, mk(3, 3, 1, 0, 80 + k));
        push(0, mk(3, 1, 0, 1, 90));
        check("R2 ready low when full", FW'(in_ready[0]), '0);
        in_valid[0] = 1'b1;
        in_flit[0 +: FW] = mk(3, 1, 0, 1, 99);
        repeat (3) @(negedge clk);
        in_valid[0] = 1'b0;
        check("R2 ready still low", FW'(in_ready[0]), '0);
        check("R9 held valid", FW'(out_valid[3]), FW'(1));
        check("R9 held flit", out_flit[3*FW +: FW], mk(3, 0, 0, 0, 80));
        check("R8 north idle behind blocked head", FW'(out_valid[1]), '0);
        out_ready[3] = 1'b1;
        repeat (16) @(negedge clk);
        check("R2 east count", FW'(log_n[3]), FW'(4));
        check("R2 east order last", log_f[3][3], mk(3, 0, 0, 0, 83));
        check("R2 north only accepted flit", FW'(log_n[1]), FW'(1));
        check("R8 north flit", log_f[1][0], mk(3, 0, 0, 0, 90));
        check("R2 ready back", FW'(in_ready[0]), FW'(1));

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog R5: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule